// File: doc/BRIEF.md
# ATAPI Packet Command Issue Sequencer

This block issues a packet command to an ATAPI device through its task-file registers. One start pulse runs the whole sequence: an optional wait for the device to drop BSY, the drive/head select with its settle time, a second BSY check, and the writes of the device-control, byte-count, sector, count, feature and command registers. Then comes either an immediate return, so that the host waits for the device to interrupt, or a bounded status poll for the device's request for the command packet. Every delay is a count of clock cycles derived from the clock period and nanosecond parameters.

The block also runs the device-reset sequence for a single drive. A controller-level reset applies that sequence to drive 0 and then to drive 1, skipping any drive that is not marked as a packet device. A one-cycle done pulse carries the outcome code together with an error flag and a warning flag. Requests that arrive while a sequence is running are dropped.

Top module: `atapi_issue_seq`

## Requirements
- R1: After reset the block is idle: busy_o, done_o, bus_we_o and bus_re_o are all 0.
- R2: When bsy_wait_en_i is set, nothing is written until status bit 7 (BSY), read from register address 8, is 0. If BSY stays set for the whole BSY window (BSY_TMO_NS), the result is BUSY (code 2) with err_o = 1 and no register is written.
- R3: drv_head_i is written first, to address 6. No bus access follows for at least SETTLE_NS worth of cycles. BSY must then clear within the BSY window; otherwise the result is BUSY (code 2) with err_o = 0 and only the select has been written.
- R4: After the select, the writes follow this order: 0x08 (interrupts enabled) to address 9, byte-count low to address 4, byte-count high to address 5, sector to address 3, count to address 2, feature to address 1, and the opcode to address 7 last.
- R5: The feature byte is 0x01 when dma_i is set and 0x00 otherwise.
- R6: The opcode write is followed by at least the settle time. Without no_cdb_irq_i the result is then OKAY (code 0).
- R7: With no_cdb_irq_i, status is polled until BSY (bit 7) is 0 and at least one of DRQ (bit 3), ERR (bit 0) or DF (bit 5) is 1, or until the DRQ window (DRQ_TMO_NS) expires. The result is CDB-ready (code 1) in both cases.
- R8: Device reset of drive d writes 0xA0|(d<<4) to address 6, waits the settle time, writes 0x08 to address 7, waits, writes the select again, waits, and then polls for BSY clear for up to RST_TMO_NS. A timeout only sets warn_o. The result is OKAY (code 0).
- R9: A controller reset runs the device reset on drive 0 and then on drive 1. Only drives whose bit in pkt_drv_i is 1 are reset. With no such drive it completes with no writes.
- R10: Starts and resets that arrive while busy_o is 1 are ignored. When requests coincide in the idle state, controller reset wins over device reset, which wins over start. done_o is a single-cycle pulse that returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Issue-command request |
| dev_rst_i | input | 1 | Device-reset request for the drive in drv_head_i bit 4 |
| ctl_rst_i | input | 1 | Controller-reset request |
| pkt_drv_i | input | 2 | Packet-device mark per drive (bit 0 = drive 0) |
| drv_head_i | input | 8 | Drive/head register value |
| bcnt_i | input | 16 | Byte-count value |
| sector_i | input | 8 | Sector register value |
| count_i | input | 8 | Count register value |
| cmd_i | input | 8 | Command opcode |
| dma_i | input | 1 | DMA-mode flag |
| bsy_wait_en_i | input | 1 | Enable BSY wait before the select |
| no_cdb_irq_i | input | 1 | Device gives no interrupt for the packet; poll instead |
| bus_we_o | output | 1 | Register write strobe |
| bus_re_o | output | 1 | Status read strobe |
| bus_addr_o | output | 4 | Register address |
| bus_wdata_o | output | 8 | Write data |
| bus_rdata_i | input | 8 | Status read data, valid in the same cycle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 0 OKAY, 1 CDB-ready, 2 BUSY |
| err_o | output | 1 | Pre-select BSY wait timed out |
| warn_o | output | 1 | A reset BSY window timed out |

## Verification
The cases that are hardest to reach are the ones that depend on the device status changing partway through a sequence: BSY clearing only after many poll cycles, or BSY never clearing so that a window runs out. The bench models the status register as a variable that it can schedule to change at a chosen cycle. It records every write and its cycle number, so that settle gaps and timeout lengths can be measured against the nanosecond parameters, which are scaled down. The ignore rule is exercised by pulsing start and reset in the middle of a running command and then checking that the logged write stream still carries only the first opcode.

// File: rtl/atapi_seq_pkg.sv
package atapi_seq_pkg;
  localparam logic [3:0] TF_FEAT     = 4'd1;
  localparam logic [3:0] TF_COUNT    = 4'd2;
  localparam logic [3:0] TF_SECTOR   = 4'd3;
  localparam logic [3:0] TF_BCNT_LO  = 4'd4;
  localparam logic [3:0] TF_BCNT_HI  = 4'd5;
  localparam logic [3:0] TF_DRV_HEAD = 4'd6;
  localparam logic [3:0] TF_CMD      = 4'd7;
  localparam logic [3:0] TF_ALT_STAT = 4'd8;
  localparam logic [3:0] TF_DEV_CTL  = 4'd9;

  localparam int ST_BSY = 7;
  localparam int ST_DF  = 5;
  localparam int ST_DRQ = 3;
  localparam int ST_ERR = 0;

  localparam logic [7:0] DEVCTL_IRQ_ON = 8'h08;
  localparam logic [7:0] FEAT_DMA      = 8'h01;
  localparam logic [7:0] OP_DEV_RESET  = 8'h08;
  localparam logic [7:0] DRV_SEL_BASE  = 8'hA0;

  typedef enum logic [1:0] {
    RES_OKAY = 2'd0,
    RES_CDB  = 2'd1,
    RES_BUSY = 2'd2
  } result_e;

  typedef enum logic [4:0] {
    S_IDLE, S_PRE_BSY, S_SEL, S_SEL_SET, S_SEL_BSY, S_DEVCTL, S_BCL, S_BCH,
    S_SEC, S_CNT, S_FEAT, S_CMD, S_CMD_SET, S_DRQ,
    S_R_PICK, S_R_SEL, S_R_SET1, S_R_CMD, S_R_SET2, S_R_RESEL, S_R_SET3, S_R_BSY,
    S_DONE
  } seq_state_e;
endpackage

// File: rtl/atapi_seq_timer.sv
module atapi_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R3
  tmr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(val_i));
  // R7
  tmr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/atapi_status_eval.sv
module atapi_status_eval
  import atapi_seq_pkg::*;
(
  input  logic [7:0] st_i,
  output logic       bsy_o,
  output logic       req_o
);
  assign bsy_o = st_i[ST_BSY];
  assign req_o = !st_i[ST_BSY] && (st_i[ST_DRQ] || st_i[ST_ERR] || st_i[ST_DF]);
endmodule

// File: rtl/atapi_issue_seq.sv
module atapi_issue_seq
  import atapi_seq_pkg::*;
#(
  parameter longint unsigned CLK_PERIOD_NS = 5,
  parameter longint unsigned SETTLE_NS     = 400,
  parameter longint unsigned BSY_TMO_NS    = 64'd5_000_000_000,
  parameter longint unsigned DRQ_TMO_NS    = 64'd4_000_000_000,
  parameter longint unsigned RST_TMO_NS    = 64'd6_000_000_000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        dev_rst_i,
  input  logic        ctl_rst_i,
  input  logic [1:0]  pkt_drv_i,
  input  logic [7:0]  drv_head_i,
  input  logic [15:0] bcnt_i,
  input  logic [7:0]  sector_i,
  input  logic [7:0]  count_i,
  input  logic [7:0]  cmd_i,
  input  logic        dma_i,
  input  logic        bsy_wait_en_i,
  input  logic        no_cdb_irq_i,
  output logic        bus_we_o,
  output logic        bus_re_o,
  output logic [3:0]  bus_addr_o,
  output logic [7:0]  bus_wdata_o,
  input  logic [7:0]  bus_rdata_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [1:0]  result_o,
  output logic        err_o,
  output logic        warn_o
);
  localparam longint unsigned SETTLE_CYC = (SETTLE_NS  + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam longint unsigned BSY_CYC    = (BSY_TMO_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam longint unsigned DRQ_CYC    = (DRQ_TMO_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam longint unsigned RST_CYC    = (RST_TMO_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam longint unsigned MAX_A      = (BSY_CYC > DRQ_CYC) ? BSY_CYC : DRQ_CYC;
  localparam longint unsigned MAX_B      = (RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC;
  localparam longint unsigned MAX_CYC    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int              TW         = $clog2(MAX_CYC + 1);

  localparam logic [TW-1:0] LD_SETTLE = TW'(SETTLE_CYC - 1);
  localparam logic [TW-1:0] LD_BSY    = TW'(BSY_CYC - 1);
  localparam logic [TW-1:0] LD_DRQ    = TW'(DRQ_CYC - 1);
  localparam logic [TW-1:0] LD_RST    = TW'(RST_CYC - 1);

  seq_state_e state_q, state_d;
  logic [7:0]  dh_q, sec_q, cnt_q, cmd_q;
  logic [15:0] bcnt_q;
  logic        dma_q, nocdb_q, err_q, warn_q, cur_q;
  logic [1:0]  pend_q;
  result_e     res_q;

  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          st_bsy, st_req;
  logic [7:0]    rst_sel;

  atapi_seq_timer #(.W(TW)) u_tmr (
    .clk_i (clk_i), .rst_ni (rst_ni), .load_i (tmr_load), .val_i (tmr_val), .zero_o (tmr_zero)
  );

  atapi_status_eval u_st (.st_i (bus_rdata_i), .bsy_o (st_bsy), .req_o (st_req));

  assign rst_sel = DRV_SEL_BASE | {3'b000, cur_q, 4'b0000};

  always_comb begin
    state_d     = state_q;
    tmr_load    = 1'b0;
    tmr_val     = LD_SETTLE;
    bus_we_o    = 1'b0;
    bus_re_o    = 1'b0;
    bus_addr_o  = TF_ALT_STAT;
    bus_wdata_o = 8'h00;
    case (state_q)
      S_IDLE: begin
        if (ctl_rst_i || dev_rst_i) state_d = S_R_PICK;
        else if (start_i) begin
          if (bsy_wait_en_i) begin
            state_d = S_PRE_BSY; tmr_load = 1'b1; tmr_val = LD_BSY;
          end else state_d = S_SEL;
        end
      end
      S_PRE_BSY: begin
        bus_re_o = 1'b1;
        if (!st_bsy)       state_d = S_SEL;
        else if (tmr_zero) state_d = S_DONE;
      end
      S_SEL: begin
        bus_we_o = 1'b1; bus_addr_o = TF_DRV_HEAD; bus_wdata_o = dh_q;
        tmr_load = 1'b1; state_d = S_SEL_SET;
      end
      S_SEL_SET: if (tmr_zero) begin
        tmr_load = 1'b1; tmr_val = LD_BSY; state_d = S_SEL_BSY;
      end
      S_SEL_BSY: begin
        bus_re_o = 1'b1;
        if (!st_bsy)       state_d = S_DEVCTL;
        else if (tmr_zero) state_d = S_DONE;
      end
      S_DEVCTL: begin bus_we_o = 1'b1; bus_addr_o = TF_DEV_CTL; bus_wdata_o = DEVCTL_IRQ_ON; state_d = S_BCL; end
      S_BCL:    begin bus_we_o = 1'b1; bus_addr_o = TF_BCNT_LO; bus_wdata_o = bcnt_q[7:0];  state_d = S_BCH; end
      S_BCH:    begin bus_we_o = 1'b1; bus_addr_o = TF_BCNT_HI; bus_wdata_o = bcnt_q[15:8]; state_d = S_SEC; end
      S_SEC:    begin bus_we_o = 1'b1; bus_addr_o = TF_SECTOR;  bus_wdata_o = sec_q;        state_d = S_CNT; end
      S_CNT:    begin bus_we_o = 1'b1; bus_addr_o = TF_COUNT;   bus_wdata_o = cnt_q;        state_d = S_FEAT; end
      S_FEAT: begin
        bus_we_o = 1'b1; bus_addr_o = TF_FEAT; bus_wdata_o = dma_q ? FEAT_DMA : 8'h00;
        state_d = S_CMD;
      end
      S_CMD: begin
        bus_we_o = 1'b1; bus_addr_o = TF_CMD; bus_wdata_o = cmd_q;
        tmr_load = 1'b1; state_d = S_CMD_SET;
      end
      S_CMD_SET: if (tmr_zero) begin
        if (nocdb_q) begin
          tmr_load = 1'b1; tmr_val = LD_DRQ; state_d = S_DRQ;
        end else state_d = S_DONE;
      end
      S_DRQ: begin
        bus_re_o = 1'b1;
        if (st_req || tmr_zero) state_d = S_DONE;
      end
      S_R_PICK: state_d = (pend_q != 2'b00) ? S_R_SEL : S_DONE;
      S_R_SEL: begin
        bus_we_o = 1'b1; bus_addr_o = TF_DRV_HEAD; bus_wdata_o = rst_sel;
        tmr_load = 1'b1; state_d = S_R_SET1;
      end
      S_R_SET1: if (tmr_zero) state_d = S_R_CMD;
      S_R_CMD: begin
        bus_we_o = 1'b1; bus_addr_o = TF_CMD; bus_wdata_o = OP_DEV_RESET;
        tmr_load = 1'b1; state_d = S_R_SET2;
      end
      S_R_SET2: if (tmr_zero) state_d = S_R_RESEL;
      S_R_RESEL: begin
        bus_we_o = 1'b1; bus_addr_o = TF_DRV_HEAD; bus_wdata_o = rst_sel;
        tmr_load = 1'b1; state_d = S_R_SET3;
      end
      S_R_SET3: if (tmr_zero) begin
        tmr_load = 1'b1; tmr_val = LD_RST; state_d = S_R_BSY;
      end
      S_R_BSY: begin
        bus_re_o = 1'b1;
        if (!st_bsy || tmr_zero) state_d = S_R_PICK;
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      dh_q <= '0; sec_q <= '0; cnt_q <= '0; cmd_q <= '0; bcnt_q <= '0;
      dma_q <= 1'b0; nocdb_q <= 1'b0; err_q <= 1'b0; warn_q <= 1'b0;
      cur_q <= 1'b0; pend_q <= '0; res_q <= RES_OKAY;
    end else begin
      state_q <= state_d;
      case (state_q)
        S_IDLE: begin
          if (ctl_rst_i) begin
            pend_q <= pkt_drv_i; err_q <= 1'b0; warn_q <= 1'b0;
          end else if (dev_rst_i) begin
            pend_q <= drv_head_i[4] ? 2'b10 : 2'b01; err_q <= 1'b0; warn_q <= 1'b0;
          end else if (start_i) begin
            dh_q <= drv_head_i; bcnt_q <= bcnt_i; sec_q <= sector_i; cnt_q <= count_i;
            cmd_q <= cmd_i; dma_q <= dma_i; nocdb_q <= no_cdb_irq_i;
            err_q <= 1'b0; warn_q <= 1'b0;
          end
        end
        S_PRE_BSY: if (st_bsy && tmr_zero) begin err_q <= 1'b1; res_q <= RES_BUSY; end
        S_SEL_BSY: if (st_bsy && tmr_zero) res_q <= RES_BUSY;
        S_CMD_SET: if (tmr_zero && !nocdb_q) res_q <= RES_OKAY;
        S_DRQ:     res_q <= RES_CDB;
        S_R_PICK: begin
          if (pend_q[0])      begin cur_q <= 1'b0; pend_q[0] <= 1'b0; end
          else if (pend_q[1]) begin cur_q <= 1'b1; pend_q[1] <= 1'b0; end
          else res_q <= RES_OKAY;
        end
        S_R_BSY: if (st_bsy && tmr_zero) warn_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign busy_o   = (state_q != S_IDLE);
  assign done_o   = (state_q == S_DONE);
  assign result_o = res_q;
  assign err_o    = err_q;
  assign warn_o   = warn_q;

  // R3
  sel_settle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_o && bus_addr_o == TF_DRV_HEAD && SETTLE_CYC > 1) |=> (!bus_we_o && !bus_re_o));
  // R4
  cmd_after_feat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_o && bus_addr_o == TF_CMD && state_q == S_CMD) |-> $past(bus_we_o && bus_addr_o == TF_FEAT));
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
  // R10
  ignore_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && start_i) |=> $stable(cmd_q));
  // R2
  err_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> result_o == RES_BUSY);
  // R8
  warn_okay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && warn_o) |-> result_o == RES_OKAY);
endmodule

// File: tb/tb_atapi_issue_seq.sv
`timescale 1ns/1ps
module tb_atapi_issue_seq;
  localparam int SET = 8, BSYW = 200, DRQW = 160, RSTW = 240;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, dev_rst = 0, ctl_rst = 0, dma = 0, bw = 0, nc = 0;
  logic [1:0] pkt = 0;
  logic [7:0] dh = 0, sec = 0, cnt = 0, cmd = 0;
  logic [15:0] bcnt = 0;
  logic we, re, busy, done, err, warn;
  logic [3:0] addr;
  logic [7:0] wdata;
  logic [1:0] res;
  logic [7:0] dev_st = 8'h00, st_next = 8'h00;
  int st_chg_cyc = -1;

  int checks = 0, fails = 0, cyc = 0, n = 0;
  int la[64], ld[64], lc[64];
  int d_cyc, d_res, d_err, d_warn;

  always #2.5 clk = ~clk;

  atapi_issue_seq #(.CLK_PERIOD_NS(5), .SETTLE_NS(40), .BSY_TMO_NS(1000),
                    .DRQ_TMO_NS(800), .RST_TMO_NS(1200)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dev_rst_i(dev_rst), .ctl_rst_i(ctl_rst),
    .pkt_drv_i(pkt), .drv_head_i(dh), .bcnt_i(bcnt), .sector_i(sec), .count_i(cnt),
    .cmd_i(cmd), .dma_i(dma), .bsy_wait_en_i(bw), .no_cdb_irq_i(nc),
    .bus_we_o(we), .bus_re_o(re), .bus_addr_o(addr), .bus_wdata_o(wdata), .bus_rdata_i(dev_st),
    .busy_o(busy), .done_o(done), .result_o(res), .err_o(err), .warn_o(warn));

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (cyc == st_chg_cyc) dev_st = st_next;
    if (we && n < 64) begin la[n] = addr; ld[n] = wdata; lc[n] = cyc; n = n + 1; end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp); end
  endtask

  task automatic clr_log(); n = 0; endtask

  task automatic wait_done();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done) begin d_cyc = cyc; d_res = res; d_err = err; d_warn = warn; return; end
    end
    chk(0, "watchdog no done", 0, 1);
  endtask

  task automatic issue(input [7:0] h, input [15:0] b, input [7:0] s, input [7:0] c,
                       input [7:0] op, input bit dm, input bit w, input bit q);
    clr_log();
    @(negedge clk);
    dh = h; bcnt = b; sec = s; cnt = c; cmd = op; dma = dm; bw = w; nc = q; start = 1;
    @(negedge clk); start = 0;
    wait_done();
  endtask

  task automatic chk_stream(input [7:0] h, input [15:0] b, input [7:0] s, input [7:0] c,
                            input [7:0] op, input bit dm, input string tag);
    int ea[8], ed[8];
    ea = '{6, 9, 4, 5, 3, 2, 1, 7};
    ed = '{h, 8'h08, b[7:0], b[15:8], s, c, dm ? 8'h01 : 8'h00, op};
    chk(n == 8, {tag, " write count"}, n, 8);
    for (int i = 0; i < 8; i++) begin
      chk(la[i] == ea[i], {tag, " addr"}, la[i], ea[i]);
      chk(ld[i] == ed[i], {tag, " data"}, ld[i], ed[i]);
    end
  endtask

  task automatic t_reset_state();
    chk(!busy && !done && !we && !re, "R1 reset idle", {busy, done, we, re}, 0);
  endtask

  task automatic t_basic();
    dev_st = 8'h00;
    issue(8'hA0, 16'h1234, 8'h5A, 8'h3C, 8'hA0, 0, 0, 0);
    chk_stream(8'hA0, 16'h1234, 8'h5A, 8'h3C, 8'hA0, 0, "R4 basic");
    chk(ld[6] == 8'h00, "R5 feature pio", ld[6], 0);
    chk(lc[1] - lc[0] >= SET + 1, "R3 select settle", lc[1] - lc[0], SET + 1);
    chk(d_cyc - lc[7] >= SET, "R6 cmd settle", d_cyc - lc[7], SET);
    chk(d_res == 0 && d_err == 0, "R6 okay", d_res, 0);
  endtask

  task automatic t_dma_drq();
    dev_st = 8'h08;
    issue(8'hB0, 16'h0800, 8'h01, 8'h02, 8'hA0, 1, 0, 1);
    chk_stream(8'hB0, 16'h0800, 8'h01, 8'h02, 8'hA0, 1, "R4 dma");
    chk(ld[6] == 8'h01, "R5 feature dma", ld[6], 1);
    chk(d_res == 1, "R7 drq seen", d_res, 1);
    chk(d_cyc - lc[7] <= SET + 4, "R7 drq early", d_cyc - lc[7], SET + 4);
  endtask

  task automatic t_drq_err();
    dev_st = 8'h01;
    issue(8'hA0, 16'h0010, 8'h00, 8'h00, 8'hA0, 0, 0, 1);
    chk(d_res == 1 && d_cyc - lc[7] <= SET + 4, "R7 err ends poll", d_res, 1);
    dev_st = 8'h20;
    issue(8'hA0, 16'h0010, 8'h00, 8'h00, 8'hA0, 0, 0, 1);
    chk(d_res == 1 && d_cyc - lc[7] <= SET + 4, "R7 df ends poll", d_res, 1);
  endtask

  task automatic t_drq_timeout();
    dev_st = 8'h00;
    issue(8'hA0, 16'h0010, 8'h00, 8'h00, 8'hA0, 0, 0, 1);
    chk(d_res == 1, "R7 timeout result", d_res, 1);
    chk(d_cyc - lc[7] >= SET + DRQW, "R7 timeout length", d_cyc - lc[7], SET + DRQW);
  endtask

  task automatic t_prewait_timeout();
    int t0;
    dev_st = 8'h80; t0 = cyc;
    issue(8'hA0, 16'h0010, 8'h00, 8'h00, 8'hA0, 0, 1, 0);
    chk(n == 0, "R2 no writes", n, 0);
    chk(d_res == 2 && d_err == 1, "R2 busy+err", {d_res, d_err}, 5);
    chk(d_cyc - t0 >= BSYW, "R2 window", d_cyc - t0, BSYW);
  endtask

  task automatic t_sel_timeout();
    dev_st = 8'h80;
    issue(8'hB0, 16'h0010, 8'h00, 8'h00, 8'hA0, 0, 0, 0);
    chk(n == 1 && la[0] == 6 && ld[0] == 8'hB0, "R3 only select", n, 1);
    chk(d_res == 2 && d_err == 0, "R3 busy no err", {d_res, d_err}, 4);
  endtask

  task automatic t_prewait_late();
    dev_st = 8'h80; st_next = 8'h00; st_chg_cyc = cyc + 50;
    issue(8'hA0, 16'h4321, 8'h07, 8'h09, 8'hBE, 0, 1, 0);
    chk_stream(8'hA0, 16'h4321, 8'h07, 8'h09, 8'hBE, 0, "R2 late clear");
    chk(lc[0] >= st_chg_cyc, "R2 no early write", lc[0], st_chg_cyc);
    chk(d_res == 0 && d_err == 0, "R2 late okay", d_res, 0);
    st_chg_cyc = -1;
  endtask

  task automatic t_ignore_busy();
    dev_st = 8'h00; clr_log();
    @(negedge clk);
    dh = 8'hA0; bcnt = 16'h0202; sec = 8'h11; cnt = 8'h22; cmd = 8'hA0; dma = 0; bw = 0; nc = 0; start = 1;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    cmd = 8'h55; start = 1; dev_rst = 1; ctl_rst = 1; pkt = 2'b11;
    @(negedge clk); start = 0; dev_rst = 0; ctl_rst = 0; cmd = 8'hA0;
    chk(busy, "R10 still busy", busy, 1);
    wait_done();
    chk_stream(8'hA0, 16'h0202, 8'h11, 8'h22, 8'hA0, 0, "R10 ignored");
    @(negedge clk);
    chk(!busy && !done, "R10 done one cycle", {busy, done}, 0);
    repeat (5) @(negedge clk);
    chk(n == 8, "R10 nothing after", n, 8);
  endtask

  task automatic t_dev_reset(input bit stuck);
    dev_st = stuck ? 8'h80 : 8'h00; clr_log();
    @(negedge clk); dh = 8'hB0; dev_rst = 1;
    @(negedge clk); dev_rst = 0;
    wait_done();
    chk(n == 3, "R8 write count", n, 3);
    chk(la[0] == 6 && ld[0] == 8'hB0 && la[1] == 7 && ld[1] == 8'h08 && la[2] == 6 && ld[2] == 8'hB0,
        "R8 sequence", {ld[0], ld[1], ld[2]}, 24'hB008B0);
    chk(lc[1] - lc[0] >= SET && lc[2] - lc[1] >= SET, "R8 settles", lc[2] - lc[1], SET);
    chk(d_res == 0 && d_warn == stuck, "R8 result/warn", {d_res, d_warn}, {2'b00, stuck});
    if (stuck) chk(d_cyc - lc[2] >= SET + RSTW, "R8 reset window", d_cyc - lc[2], SET + RSTW);
  endtask

  task automatic t_ctl_reset(input [1:0] m);
    int exp_n, k;
    int exp_d[6];
    exp_n = 0;
    if (m[0]) begin exp_d[0] = 8'hA0; exp_d[1] = 8'h08; exp_d[2] = 8'hA0; exp_n = 3; end
    if (m[1]) begin exp_d[exp_n] = 8'hB0; exp_d[exp_n+1] = 8'h08; exp_d[exp_n+2] = 8'hB0; exp_n += 3; end
    dev_st = 8'h00; clr_log();
    @(negedge clk); pkt = m; ctl_rst = 1; dev_rst = 1; start = 1; dh = 8'hB0; cmd = 8'hA0; bw = 0;
    @(negedge clk); ctl_rst = 0; dev_rst = 0; start = 0;
    wait_done();
    chk(n == exp_n, "R9 write count", n, exp_n);
    k = (n < exp_n) ? n : exp_n;
    for (int i = 0; i < k; i++)
      chk(ld[i] == exp_d[i], "R9 order/priority", ld[i], exp_d[i]);
    chk(d_res == 0 && d_warn == 0, "R9 result", d_res, 0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_basic();
    t_dma_drq();
    t_drq_err();
    t_drq_timeout();
    t_prewait_timeout();
    t_sel_timeout();
    t_prewait_late();
    t_ignore_busy();
    t_dev_reset(0);
    t_dev_reset(1);
    t_ctl_reset(2'b11);
    t_ctl_reset(2'b10);
    t_ctl_reset(2'b00);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule